// File: doc/BRIEF.md
# Atomic Compare-and-Swap Memory Unit

This unit performs one indivisible compare-and-swap on a single-port synchronous memory. A requester presents an address, a size selector (32-bit word or 64-bit doubleword), a compare operand, a swap operand and two ordering flags: acquire and release. The unit reads the addressed location and compares the value it reads with the compare operand. It writes the swap operand back only when the two are equal. It always returns the value it read. If the access faults, it returns the compare operand instead, so the destination register appears unchanged.

A second requester shares the same memory port. The unit holds a bus lock for the whole read, compare and write sequence. While the lock is held, the second requester gets no grant, so no other access can slip between the read and the write. The read cycle also drives a one-cycle pulse that clears any exclusive reservation held on that address. This pulse is sent whether or not the compare succeeds. The memory answers in the same cycle as the access: the read data and the error flag are valid while `mem_req` is high.

Top module: `cas_unit`

## Requirements
- R1: `req_ready` is high only while the unit is idle and out of reset. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Only one request is outstanding at a time, and `req_ready` returns high in the cycle after `rsp_done`.
- R2: For an aligned request, the first memory access is a read (`mem_we`=0) to the request address. During that read, `mem_dword` is 1 for a doubleword and 0 for a word.
- R3: A write (`mem_we`=1) of the swap operand to the same address is issued if and only if the read value equals the compare operand. When they differ, no write is issued and memory keeps its value.
- R4: `bus_lock` is high from the read cycle through the write cycle. While it is high, `ext_gnt` stays low, and a held secondary request is granted in the response cycle.
- R5: `rsp_old` carries the value read from memory whether or not the swap happened. `rsp_ok` is 1 only when the write completed without error.
- R6: In word mode (`req_dword`=0), only bits 31:0 are compared and written. A word at an address with bit 2 set occupies the upper half of the 64-bit memory line. `mem_wdata[63:32]` is zero and `rsp_old[63:32]` is zero.
- R7: `mem_acq` follows the request's acquire flag on the read access only. `mem_rel` follows the release flag on the write access only. All four flag combinations behave this way.
- R8: `mon_clr` pulses exactly once for each request that reaches memory, in the read cycle, with `mon_addr` equal to the address. This holds even when the compare fails.
- R9: A doubleword address with bits 2:0 not zero, or a word address with bits 1:0 not zero, gives `rsp_fault`=1 with no memory access and no `mon_clr`. `rsp_old` then equals the size-masked compare operand.
- R10: `mem_err` during the read or the write gives `rsp_fault`=1 and `rsp_ok`=0, and `rsp_old` equals the size-masked compare operand. After a read error, no write is issued.
- R11: `rsp_done` is a one-cycle pulse. Counting the accept edge as the start, it comes in cycle 1 for a misaligned request, cycle 2 after a read error, cycle 3 after a failed compare, and cycle 4 after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_addr | input | AW | Location address (zero offset) |
| req_dword | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| req_cmp | input | DW | Compare operand |
| req_swp | input | DW | Swap operand |
| req_acq | input | 1 | Acquire ordering on the load |
| req_rel | input | 1 | Release ordering on the store |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_ok | output | 1 | Swap written |
| rsp_fault | output | 1 | Misalignment or memory error |
| rsp_old | output | DW | Read value, or compare operand on fault |
| bus_lock | output | 1 | Atomic sequence owns the memory port |
| mon_clr | output | 1 | Exclusive reservation clear pulse |
| mon_addr | output | AW | Address for the clear |
| ext_req | input | 1 | Secondary requester access request |
| ext_we | input | 1 | Secondary requester write enable |
| ext_addr | input | AW | Secondary requester address (doubleword) |
| ext_wdata | input | DW | Secondary requester write data |
| ext_gnt | output | 1 | Secondary access performed this cycle |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_dword | output | 1 | Access size |
| mem_wdata | output | DW | Memory write data |
| mem_acq | output | 1 | Acquire flag on this access |
| mem_rel | output | 1 | Release flag on this access |
| mem_rdata | input | DW | Memory read data, valid in the access cycle |
| mem_err | input | 1 | Synchronous abort for the access |

## Verification
A secondary write to the same address can arrive while the atomic sequence is running. This is where two functions of the block meet: the lock's exclusion and the grant to the secondary port. The bench provokes it by raising a secondary write in the read cycle of a successful swap and holding it. The case passes when `ext_gnt` stays low through the compare and write cycles, goes high in the response cycle, the swap returns the value from before either write, and memory ends with the secondary data.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_CMP   = 3'd2,
    ST_WRITE = 3'd3,
    ST_RESP  = 3'd4
  } cas_state_e;
endpackage

// File: rtl/cas_fsm.sv
module cas_fsm
  import cas_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sn,
  input  logic       accept,
  input  logic       misalign,
  input  logic       mem_err,
  input  logic       match,
  output cas_state_e state
);
  cas_state_e state_q;
  cas_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = misalign ? ST_RESP : ST_READ;
      ST_READ:  state_d = mem_err ? ST_RESP : ST_CMP;
      ST_CMP:   state_d = match ? ST_WRITE : ST_RESP;
      ST_WRITE: state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/cas_data.sv
module cas_data
  import cas_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
)(
  input  logic          clk,
  input  logic          rst_sn,
  input  cas_state_e    state,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic          req_dword,
  input  logic [DW-1:0] req_cmp,
  input  logic [DW-1:0] req_swp,
  input  logic          req_acq,
  input  logic          req_rel,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_err,
  output logic          misalign,
  output logic          match,
  output logic          dword_q,
  output logic          u_req,
  output logic          u_we,
  output logic [AW-1:0] u_addr,
  output logic [DW-1:0] u_wdata,
  output logic          u_acq,
  output logic          u_rel,
  output logic          rsp_done,
  output logic          rsp_ok,
  output logic          rsp_fault,
  output logic [DW-1:0] rsp_old
);
  localparam int WW = DW / 2;
  localparam logic [DW-1:0] WORD_MASK = {{(DW-WW){1'b0}}, {WW{1'b1}}};
  localparam logic [DW-1:0] FULL_MASK = {DW{1'b1}};

  logic [AW-1:0] addr_q;
  logic [DW-1:0] cmp_q, swp_q, old_q;
  logic          acq_q, rel_q, fault_q, wrote_q;
  logic [DW-1:0] mask_q, mask_in;
  logic          in_read, in_write;
  logic          ld_op, ld_old;

  assign in_read  = (state == ST_READ);
  assign in_write = (state == ST_WRITE);
  assign ld_op    = accept;
  assign ld_old   = in_read;

  assign mask_in  = req_dword ? FULL_MASK : WORD_MASK;
  assign misalign = req_dword ? (req_addr[2:0] != 3'd0) : (req_addr[1:0] != 2'd0);

  // operand registers: no reset, loaded under enable
  always_ff @(posedge clk) begin
    if (ld_op) begin
      addr_q <= req_addr;
      cmp_q  <= req_cmp & mask_in;
      swp_q  <= req_swp & mask_in;
      mask_q <= mask_in;
    end
    if (ld_old) old_q <= mem_rdata & mask_q;
  end

  // control flags with reset
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      dword_q <= 1'b0;
      acq_q   <= 1'b0;
      rel_q   <= 1'b0;
      fault_q <= 1'b0;
      wrote_q <= 1'b0;
    end else begin
      if (ld_op) begin
        dword_q <= req_dword;
        acq_q   <= req_acq;
        rel_q   <= req_rel;
        fault_q <= misalign;
        wrote_q <= 1'b0;
      end
      if (in_read && mem_err) fault_q <= 1'b1;
      if (in_write) begin
        if (mem_err) fault_q <= 1'b1;
        else         wrote_q <= 1'b1;
      end
    end
  end

  assign match   = (old_q == cmp_q);

  assign u_req   = in_read | in_write;
  assign u_we    = in_write;
  assign u_addr  = addr_q;
  assign u_wdata = swp_q;
  assign u_acq   = in_read & acq_q;
  assign u_rel   = in_write & rel_q;

  assign rsp_done  = (state == ST_RESP);
  assign rsp_fault = rsp_done & fault_q;
  assign rsp_ok    = rsp_done & wrote_q & ~fault_q;
  assign rsp_old   = fault_q ? cmp_q : old_q;
endmodule

// File: rtl/cas_portmux.sv
module cas_portmux #(
  parameter int AW = 32,
  parameter int DW = 64
)(
  input  logic          lock,
  input  logic          u_req,
  input  logic          u_we,
  input  logic [AW-1:0] u_addr,
  input  logic          u_dword,
  input  logic [DW-1:0] u_wdata,
  input  logic          u_acq,
  input  logic          u_rel,
  input  logic          ext_req,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  input  logic [DW-1:0] ext_wdata,
  output logic          ext_gnt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          mem_dword,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_acq,
  output logic          mem_rel
);
  assign ext_gnt = ext_req & ~lock;

  always_comb begin
    if (lock) begin
      mem_req   = u_req;
      mem_we    = u_we;
      mem_addr  = u_addr;
      mem_dword = u_dword;
      mem_wdata = u_wdata;
      mem_acq   = u_acq;
      mem_rel   = u_rel;
    end else begin
      mem_req   = ext_req;
      mem_we    = ext_we;
      mem_addr  = ext_addr;
      mem_dword = 1'b1;
      mem_wdata = ext_wdata;
      mem_acq   = 1'b0;
      mem_rel   = 1'b0;
    end
  end
endmodule

// File: rtl/cas_unit.sv
module cas_unit
  import cas_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_dword,
  input  logic [DW-1:0] req_cmp,
  input  logic [DW-1:0] req_swp,
  input  logic          req_acq,
  input  logic          req_rel,
  output logic          rsp_done,
  output logic          rsp_ok,
  output logic          rsp_fault,
  output logic [DW-1:0] rsp_old,
  output logic          bus_lock,
  output logic          mon_clr,
  output logic [AW-1:0] mon_addr,
  input  logic          ext_req,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  input  logic [DW-1:0] ext_wdata,
  output logic          ext_gnt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          mem_dword,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_acq,
  output logic          mem_rel,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_err
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sn = rs_q[SYNC_STAGES-1];

  cas_state_e    state;
  logic          accept, misalign, match, dword_q;
  logic          u_req, u_we, u_acq, u_rel;
  logic [AW-1:0] u_addr;
  logic [DW-1:0] u_wdata;

  assign req_ready = rst_sn & (state == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign bus_lock  = (state == ST_READ) | (state == ST_CMP) | (state == ST_WRITE);
  assign mon_clr   = (state == ST_READ);
  assign mon_addr  = u_addr;

  cas_fsm u_fsm (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .accept   (accept),
    .misalign (misalign),
    .mem_err  (mem_err),
    .match    (match),
    .state    (state)
  );

  cas_data #(.AW(AW), .DW(DW)) u_data (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .state     (state),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_dword (req_dword),
    .req_cmp   (req_cmp),
    .req_swp   (req_swp),
    .req_acq   (req_acq),
    .req_rel   (req_rel),
    .mem_rdata (mem_rdata),
    .mem_err   (mem_err),
    .misalign  (misalign),
    .match     (match),
    .dword_q   (dword_q),
    .u_req     (u_req),
    .u_we      (u_we),
    .u_addr    (u_addr),
    .u_wdata   (u_wdata),
    .u_acq     (u_acq),
    .u_rel     (u_rel),
    .rsp_done  (rsp_done),
    .rsp_ok    (rsp_ok),
    .rsp_fault (rsp_fault),
    .rsp_old   (rsp_old)
  );

  cas_portmux #(.AW(AW), .DW(DW)) u_mux (
    .lock      (bus_lock),
    .u_req     (u_req),
    .u_we      (u_we),
    .u_addr    (u_addr),
    .u_dword   (dword_q),
    .u_wdata   (u_wdata),
    .u_acq     (u_acq),
    .u_rel     (u_rel),
    .ext_req   (ext_req),
    .ext_we    (ext_we),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata),
    .ext_gnt   (ext_gnt),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_dword (mem_dword),
    .mem_wdata (mem_wdata),
    .mem_acq   (mem_acq),
    .mem_rel   (mem_rel)
  );
endmodule

// File: rtl/cas_unit_sva.sv
module cas_unit_sva
  import cas_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
)(
  input logic          clk,
  input logic          rst_sn,
  input cas_state_e    state,
  input logic          match,
  input logic          dword_q,
  input logic          req_ready,
  input logic          rsp_done,
  input logic          rsp_ok,
  input logic          rsp_fault,
  input logic [DW-1:0] rsp_old,
  input logic          mon_clr,
  input logic          ext_gnt,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_acq,
  input logic          mem_rel
);
  localparam int WW = DW / 2;

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_done |=> req_ready); // R1
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_sn)
    (state == ST_WRITE) |-> ($past(state) == ST_CMP && $past(state, 2) == ST_READ)); // R2
  AST_WRITE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_sn)
    (state == ST_WRITE) |-> $past(match)); // R3
  AST_EXT_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_sn)
    ext_gnt |-> (state == ST_IDLE || state == ST_RESP)); // R4
  AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    (rsp_done && !dword_q) |-> (rsp_old[DW-1:WW] == '0)); // R6
  AST_WORD_WDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    (state == ST_WRITE && !dword_q) |-> (mem_wdata[DW-1:WW] == '0)); // R6
  AST_ACQ_ON_READ: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_acq |-> (mem_req && !mem_we)); // R7
  AST_REL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_rel |-> (mem_req && mem_we)); // R7
  AST_CLEAR_IN_READ: assert property (@(posedge clk) disable iff (!rst_sn)
    mon_clr |-> (mem_req && !mem_we)); // R8
  AST_FAULT_NOT_OK: assert property (@(posedge clk) disable iff (!rst_sn)
    (rsp_done && rsp_fault) |-> !rsp_ok); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_done |=> !rsp_done); // R11
endmodule

bind cas_unit cas_unit_sva #(.AW(AW), .DW(DW)) u_sva (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .state     (state),
  .match     (match),
  .dword_q   (dword_q),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .rsp_ok    (rsp_ok),
  .rsp_fault (rsp_fault),
  .rsp_old   (rsp_old),
  .mon_clr   (mon_clr),
  .ext_gnt   (ext_gnt),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .mem_acq   (mem_acq),
  .mem_rel   (mem_rel)
);

// File: tb/cas_unit_tb.sv
module cas_unit_tb_top;
  localparam int AW = 32;
  localparam int DW = 64;

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_ready, req_dword, req_acq, req_rel;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_cmp, req_swp;
  logic          rsp_done, rsp_ok, rsp_fault;
  logic [DW-1:0] rsp_old;
  logic          bus_lock, mon_clr;
  logic [AW-1:0] mon_addr;
  logic          ext_req, ext_we, ext_gnt;
  logic [AW-1:0] ext_addr;
  logic [DW-1:0] ext_wdata;
  logic          mem_req, mem_we, mem_dword, mem_acq, mem_rel, mem_err;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int n_chk = 0;
  int n_bad = 0;

  cas_unit #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_dword(req_dword), .req_cmp(req_cmp), .req_swp(req_swp),
    .req_acq(req_acq), .req_rel(req_rel),
    .rsp_done(rsp_done), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault), .rsp_old(rsp_old),
    .bus_lock(bus_lock), .mon_clr(mon_clr), .mon_addr(mon_addr),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_gnt(ext_gnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_dword(mem_dword),
    .mem_wdata(mem_wdata), .mem_acq(mem_acq), .mem_rel(mem_rel),
    .mem_rdata(mem_rdata), .mem_err(mem_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // memory model: 16 doubleword lines, same-cycle answer
  logic [DW-1:0] mem_arr [16];
  logic [3:0]    m_idx;
  logic [31:0]   m_word;
  assign m_idx = mem_addr[6:3];

  function automatic logic [DW-1:0] init_line(int i);
    return {32'hA000_0000 + 32'(i), 32'h5000_0000 + 32'(i)};
  endfunction

  always_comb begin
    mem_err   = mem_req && ((mem_addr[31:28] == 4'hF) || (mem_we && mem_addr[31:28] == 4'hE));
    m_word    = mem_addr[2] ? mem_arr[m_idx][63:32] : mem_arr[m_idx][31:0];
    mem_rdata = mem_dword ? mem_arr[m_idx] : {32'h0, m_word};
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem_arr[i] <= init_line(i);
    end else if (mem_req && mem_we && !mem_err) begin
      if (mem_dword)         mem_arr[m_idx] <= mem_wdata;
      else if (mem_addr[2])  mem_arr[m_idx][63:32] <= mem_wdata[31:0];
      else                   mem_arr[m_idx][31:0]  <= mem_wdata[31:0];
    end
  end

  // port monitor
  int n_rd = 0, n_wr = 0, n_mon = 0, n_acq_rd = 0, n_rel_rd = 0, n_acq_wr = 0, n_rel_wr = 0;
  logic [AW-1:0] last_rd_addr, last_mon_addr;
  logic          last_rd_dword;
  always @(posedge clk) begin
    if (rst_n && mem_req && bus_lock) begin
      if (!mem_we) begin
        n_rd++; last_rd_addr <= mem_addr; last_rd_dword <= mem_dword;
        if (mem_acq) n_acq_rd++;
        if (mem_rel) n_rel_rd++;
      end else begin
        n_wr++;
        if (mem_acq) n_acq_wr++;
        if (mem_rel) n_rel_wr++;
      end
    end
    if (rst_n && mon_clr) begin n_mon++; last_mon_addr <= mon_addr; end
  end

  task automatic check(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic run_cas(input logic [AW-1:0] a, input logic dw,
                         input logic [DW-1:0] c, input logic [DW-1:0] s,
                         input logic aq, input logic rl,
                         output logic [DW-1:0] old, output logic ok,
                         output logic flt, output int lat);
    @(negedge clk);
    check("R1 ready before request", {63'h0, req_ready}, 64'h1);
    req_addr = a; req_dword = dw; req_cmp = c; req_swp = s;
    req_acq = aq; req_rel = rl; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    old = rsp_old; ok = rsp_ok; flt = rsp_fault;
    @(negedge clk);
    check("R11 done is one cycle", {63'h0, rsp_done}, 64'h0);
    check("R1 ready after done", {63'h0, req_ready}, 64'h1);
  endtask

  logic [DW-1:0] o;
  logic          ok, flt;
  int            lat;

  task automatic t_reset();
    check("R1 reset ready", {63'h0, req_ready}, 64'h1);
    check("R11 reset done low", {63'h0, rsp_done}, 64'h0);
    check("R4 reset lock low", {63'h0, bus_lock}, 64'h0);
    check("R2 reset no access", {63'h0, mem_req}, 64'h0);
  endtask

  task automatic t_dword_hit();
    logic [DW-1:0] v, s;
    int r0, w0, m0;
    v = mem_arr[2]; s = 64'hCAFE_F00D_1234_0002;
    r0 = n_rd; w0 = n_wr; m0 = n_mon;
    run_cas(32'h10, 1'b1, v, s, 1'b0, 1'b0, o, ok, flt, lat);
    check("R2 one read", 64'(n_rd - r0), 64'd1);
    check("R2 read addr", 64'(last_rd_addr), 64'h10);
    check("R2 read size dword", {63'h0, last_rd_dword}, 64'h1);
    check("R3 one write on match", 64'(n_wr - w0), 64'd1);
    check("R3 memory swapped", mem_arr[2], s);
    check("R5 old value", o, v);
    check("R5 ok on swap", {63'h0, ok}, 64'h1);
    check("R8 clear on hit", 64'(n_mon - m0), 64'd1);
    check("R11 write latency", 64'(lat), 64'd4);
  endtask

  task automatic t_dword_miss();
    logic [DW-1:0] v;
    int w0, m0;
    v = mem_arr[4]; w0 = n_wr; m0 = n_mon;
    run_cas(32'h20, 1'b1, v ^ 64'h1, 64'h0, 1'b0, 1'b0, o, ok, flt, lat);
    check("R3 no write on mismatch", 64'(n_wr - w0), 64'd0);
    check("R3 memory kept", mem_arr[4], v);
    check("R5 old value on miss", o, v);
    check("R5 not ok on miss", {63'h0, ok}, 64'h0);
    check("R8 clear on miss", 64'(n_mon - m0), 64'd1);
    check("R8 clear address", 64'(last_mon_addr), 64'h20);
    check("R11 miss latency", 64'(lat), 64'd3);
  endtask

  task automatic t_word();
    logic [DW-1:0] v;
    v = mem_arr[3];
    run_cas(32'h1C, 1'b0, {32'hDEAD_BEEF, v[63:32]}, 64'hFFFF_FFFF_1234_5678,
            1'b0, 1'b0, o, ok, flt, lat);
    check("R6 word hit ignores upper compare", {63'h0, ok}, 64'h1);
    check("R6 word old zero-extended", o, {32'h0, v[63:32]});
    check("R6 word written upper half", mem_arr[3], {32'h1234_5678, v[31:0]});
    check("R2 read size word", {63'h0, last_rd_dword}, 64'h0);
  endtask

  task automatic t_order();
    for (int k = 0; k < 4; k++) begin
      logic aq, rl;
      logic [DW-1:0] v;
      int ar, rr, aw, rw;
      aq = k[0]; rl = k[1]; v = mem_arr[5];
      ar = n_acq_rd; rr = n_rel_rd; aw = n_acq_wr; rw = n_rel_wr;
      run_cas(32'h28, 1'b1, v, v + 64'd1, aq, rl, o, ok, flt, lat);
      check("R7 acquire on read", 64'(n_acq_rd - ar), {63'h0, aq});
      check("R7 release on write", 64'(n_rel_wr - rw), {63'h0, rl});
      check("R7 no acquire on write", 64'(n_acq_wr - aw), 64'd0);
      check("R7 no release on read", 64'(n_rel_rd - rr), 64'd0);
    end
  endtask

  task automatic t_misalign();
    int r0, m0;
    r0 = n_rd; m0 = n_mon;
    run_cas(32'h22, 1'b0, 64'h7777_7777_8888_8888, 64'h0, 1'b1, 1'b1, o, ok, flt, lat);
    check("R9 word misaligned fault", {63'h0, flt}, 64'h1);
    check("R9 word misaligned old", o, 64'h0000_0000_8888_8888);
    check("R11 misaligned latency", 64'(lat), 64'd1);
    run_cas(32'h0C, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h0, 1'b0, 1'b0, o, ok, flt, lat);
    check("R9 dword misaligned fault", {63'h0, flt}, 64'h1);
    check("R9 dword misaligned old", o, 64'h1234_5678_9ABC_DEF0);
    check("R9 no memory access", 64'(n_rd - r0), 64'd0);
    check("R9 no clear pulse", 64'(n_mon - m0), 64'd0);
  endtask

  task automatic t_rd_abort();
    int w0, m0;
    w0 = n_wr; m0 = n_mon;
    run_cas(32'hF000_0008, 1'b1, 64'h0BAD_0BAD_0BAD_0BAD, 64'h0, 1'b0, 1'b0, o, ok, flt, lat);
    check("R10 read abort fault", {63'h0, flt}, 64'h1);
    check("R10 read abort old", o, 64'h0BAD_0BAD_0BAD_0BAD);
    check("R10 no write after read abort", 64'(n_wr - w0), 64'd0);
    check("R8 clear on read abort", 64'(n_mon - m0), 64'd1);
    check("R11 read abort latency", 64'(lat), 64'd2);
  endtask

  task automatic t_wr_abort();
    logic [DW-1:0] v;
    v = mem_arr[2];
    run_cas(32'hE000_0010, 1'b1, v, 64'h5555_5555_5555_5555, 1'b0, 1'b0, o, ok, flt, lat);
    check("R10 write abort fault", {63'h0, flt}, 64'h1);
    check("R10 write abort not ok", {63'h0, ok}, 64'h0);
    check("R10 write abort old", o, v);
    check("R10 write abort memory kept", mem_arr[2], v);
    check("R11 write abort latency", 64'(lat), 64'd4);
  endtask

  task automatic t_contend();
    logic [DW-1:0] v;
    v = mem_arr[6];
    @(negedge clk);
    req_addr = 32'h30; req_dword = 1'b1; req_cmp = v; req_swp = 64'h1111_2222_3333_4444;
    req_acq = 1'b0; req_rel = 1'b0; req_valid = 1'b1;
    @(negedge clk); // read cycle
    req_valid = 1'b0;
    ext_req = 1'b1; ext_we = 1'b1; ext_addr = 32'h30; ext_wdata = 64'h9999_8888_7777_6666;
    check("R4 lock in read", {63'h0, bus_lock}, 64'h1);
    check("R4 no grant in read", {63'h0, ext_gnt}, 64'h0);
    @(negedge clk); // compare
    check("R4 no grant in compare", {63'h0, ext_gnt}, 64'h0);
    @(negedge clk); // write
    check("R4 no grant in write", {63'h0, ext_gnt}, 64'h0);
    @(negedge clk); // respond
    check("R4 grant after lock", {63'h0, ext_gnt}, 64'h1);
    check("R5 contended old", rsp_old, v);
    check("R5 contended ok", {63'h0, rsp_ok}, 64'h1);
    check("R3 swap before secondary write", mem_arr[6], 64'h1111_2222_3333_4444);
    @(negedge clk);
    ext_req = 1'b0; ext_we = 1'b0;
    check("R4 secondary write landed last", mem_arr[6], 64'h9999_8888_7777_6666);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 64'h1, 64'h0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_dword = 1'b0;
    req_cmp = '0; req_swp = '0; req_acq = 1'b0; req_rel = 1'b0;
    ext_req = 1'b0; ext_we = 1'b0; ext_addr = '0; ext_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_dword_hit();
    t_dword_miss();
    t_word();
    t_order();
    t_misalign();
    t_rd_abort();
    t_wr_abort();
    t_contend();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule